// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block turns an already-decoded instruction class of an 8-bit processor into the ordered run of bus machine cycles that the instruction needs. Each machine cycle has a kind (opcode fetch, operand read, memory read or write, stack read or write, port read or write, internal operation) and a length in T-states. Lengths differ between classes: some fetches take 5 or 6 T-states, a memory read before a write-back takes 4, and internal cycles take 5. Some cycles appear only when a condition flag or a repeat flag is set.

A decoder presents a class code with `start`. A T-state enable `t_en` paces the block. Each enabled clock ends one T-state. For every T-state the block shows the current cycle kind, the T-state number within that cycle and a cycle-start marker. It raises `done` during the final T-state of the last cycle, and it can take the next class on that same enable, so instructions follow one another with no gap.

Top module: `mcyc_seq`

## Requirements
- R1: While `rst_n` is low and after its release, the block is idle: `busy`=0, `cyc_type`=0, `done`=0 and `cyc_start`=0, whatever `start` and `t_en` do during reset.
- R2: When `t_en` and `start` are high on a clock edge and the block is idle or in its `done` T-state, it latches `iclass`, `cond_met` and `repeat_on`. From the next T-state it runs T1 of an opcode fetch with `cyc_start`=1. Later changes on `cond_met` and `repeat_on` have no effect on the running instruction.
- R3: State only moves on clocks where `t_en` is high. While `t_en` is low, `cyc_type`, `t_idx`, `done` and `busy` hold. An idle block with `start` low stays idle.
- R4: `t_idx` counts 1, 2, ... up to the cycle length inside each machine cycle (the TBASE=1 default). `cyc_start` is high only in the first T-state of each cycle.
- R5: `done` is high for the whole last T-state of the last cycle. If no new class is taken, the block is idle after it (`busy`=0, `cyc_type`=0).
- R6: `cyc_type` codes: 0 idle, 1 opcode fetch, 2 operand read, 3 operand low, 4 operand high, 5 memory read, 6 memory read low, 7 memory read high, 8 memory write, 9 memory write low, 10 memory write high, 11 stack read low, 12 stack read high, 13 stack write high, 14 stack write low, 15 port read, 16 port write, 17 internal.
- R7: Plain classes run fetch 4 followed by: class 0: read 3. Class 1: write 3. Class 4: operand low 3, high 3, read 3. Classes 5 and 27: operand low 3, high 3. Class 6: operand low 3, high 3, read low 3, read high 3. Class 7: the same with write low 3, write high 3. Codes 29 to 31 run one 4-T fetch. `cond_met` and `repeat_on` have no effect on any class outside R12 to R14.
- R8: Push (9) and restart (21) use a 5-T fetch. Loading the stack pointer from an index register (8) and decrementing an index register (26) run fetch 4, then fetch 6.
- R9: Indexed classes run fetch 4, fetch 4, operand 3, internal 5, then: load (2) read 3; store (3) write 3; read-modify-write (15) read 4 and write 3.
- R10: Read-modify-write through a pointer (13) runs fetch 4, read 4, write 3. A bit test through a pointer (14) runs fetch 4, fetch 4, read 4, with no write.
- R11: Push (9) and restart (21) write stack high 3 and then stack low 3. Pop (10) and return (28) run fetch 4, stack low 3, stack high 3. Exchange with top of stack (11) runs fetch 4, stack read low 3, stack read high 4, stack write high 3, stack write low 5.
- R12: Conditional relative jump (16) runs fetch 4, operand 3. Decrement-and-branch (17) runs fetch 5, operand 3. Both add internal 5 only when the condition is met.
- R13: Call (18) runs fetch 4, operand low 3, operand high 4, stack write high 3, stack write low 3. Conditional call (19) does the same when the condition is met, and otherwise runs fetch 4, operand low 3, operand high 3. Conditional return (20) runs fetch 5, and adds stack low 3 and stack high 3 only when the condition is met.
- R14: Block classes add internal 5 only when repeating. Move (12): fetch 4, fetch 4, read 3, write 5. Input (24): fetch 4, fetch 5, port read 4, write 3. Output (25): fetch 4, fetch 5, read 3, port write 4. Classes 22 and 23 run fetch 4, operand 3, then port read 4 or port write 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_en | input | 1 | T-state enable; each enabled clock ends one T-state |
| start | input | 1 | A new class is offered on `iclass` |
| iclass | input | CLS_W | Decoded instruction class code |
| cond_met | input | 1 | Condition of a conditional class holds |
| repeat_on | input | 1 | Block instruction repeats this pass |
| cyc_type | output | 5 | Kind of the current machine cycle (R6 codes) |
| cyc_start | output | 1 | First T-state of a machine cycle |
| t_idx | output | 3 | T-state number within the current cycle |
| done | output | 1 | Final T-state of the instruction |
| busy | output | 1 | An instruction is in progress |

## Verification
Every one of the 32 class codes is run with all four combinations of condition and repeat flag. These runs tell apart the classes whose cycle list depends on a flag and the classes that must ignore both flags. Each combination is run twice: once with the enable high on every clock, and once with two idle clocks before each enabled one. The second pass shows that outputs hold between enables and that T-state counts come only from enables. The flags are inverted right after acceptance, which shows that they are latched. A chained launch in the `done` T-state shows that instructions follow with no gap.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   localparam int KIND_W  = 5;
   localparam int LEN_W   = 3;
   localparam int MAX_CYC = 6;
   localparam int MAX_LEN = 6;

   typedef enum logic [KIND_W-1:0] {
      CK_IDLE      = 5'd0,
      CK_FETCH     = 5'd1,
      CK_OPND      = 5'd2,
      CK_OPND_LO   = 5'd3,
      CK_OPND_HI   = 5'd4,
      CK_MRD       = 5'd5,
      CK_MRD_LO    = 5'd6,
      CK_MRD_HI    = 5'd7,
      CK_MWR       = 5'd8,
      CK_MWR_LO    = 5'd9,
      CK_MWR_HI    = 5'd10,
      CK_STK_RD_LO = 5'd11,
      CK_STK_RD_HI = 5'd12,
      CK_STK_WR_HI = 5'd13,
      CK_STK_WR_LO = 5'd14,
      CK_IO_RD     = 5'd15,
      CK_IO_WR     = 5'd16,
      CK_INTERNAL  = 5'd17
   } cyc_kind_e;

   typedef enum logic [4:0] {
      K_LD_IND      = 5'd0,
      K_ST_IND      = 5'd1,
      K_LD_XD       = 5'd2,
      K_ST_XD       = 5'd3,
      K_LD_ABS      = 5'd4,
      K_LD_IMM16    = 5'd5,
      K_LD_PAIR_ABS = 5'd6,
      K_ST_PAIR_ABS = 5'd7,
      K_SP_FROM_X   = 5'd8,
      K_PUSH        = 5'd9,
      K_POP         = 5'd10,
      K_XCHG_TOS    = 5'd11,
      K_BLK_MOVE    = 5'd12,
      K_RMW_IND     = 5'd13,
      K_TEST_IND    = 5'd14,
      K_RMW_XD      = 5'd15,
      K_JREL_CC     = 5'd16,
      K_DEC_BR      = 5'd17,
      K_CALL        = 5'd18,
      K_CALL_CC     = 5'd19,
      K_RET_CC      = 5'd20,
      K_RESTART     = 5'd21,
      K_IN_IMM      = 5'd22,
      K_OUT_IMM     = 5'd23,
      K_BLK_IN      = 5'd24,
      K_BLK_OUT     = 5'd25,
      K_DEC_X       = 5'd26,
      K_JUMP        = 5'd27,
      K_RET         = 5'd28
   } icls_e;

   typedef struct packed {
      cyc_kind_e        kind;
      logic [LEN_W-1:0] len;
   } cyc_t;

   function automatic cyc_t mk(cyc_kind_e k, int unsigned l);
      cyc_t c;
      c.kind = k;
      c.len  = LEN_W'(l);
      return c;
   endfunction

endpackage

// File: rtl/mcyc_table.sv
module mcyc_table
   import mcyc_pkg::*;
#(
   parameter int CLS_W = 5,
   parameter int IDX_W = 3
) (
   input  logic [CLS_W-1:0] cls,
   input  logic             cond,
   input  logic             rep,
   input  logic [IDX_W-1:0] idx,
   output cyc_t             cur,
   output logic             last
);

   cyc_t       lst [MAX_CYC];
   int         cnt;
   logic       in_rng;
   logic [4:0] code;

   always_comb begin
      in_rng = ((cls >> 5) == '0);
      code   = cls[4:0];
      for (int i = 0; i < MAX_CYC; i++) lst[i] = mk(CK_IDLE, 1);
      lst[0] = mk(CK_FETCH, 4);
      cnt    = 1;
      if (in_rng) begin
         case (icls_e'(code))
            K_LD_IND: begin
               lst[1] = mk(CK_MRD, 3); cnt = 2;
            end
            K_ST_IND: begin
               lst[1] = mk(CK_MWR, 3); cnt = 2;
            end
            K_LD_XD: begin
               lst[1] = mk(CK_FETCH, 4);    lst[2] = mk(CK_OPND, 3);
               lst[3] = mk(CK_INTERNAL, 5); lst[4] = mk(CK_MRD, 3);
               cnt = 5;
            end
            K_ST_XD: begin
               lst[1] = mk(CK_FETCH, 4);    lst[2] = mk(CK_OPND, 3);
               lst[3] = mk(CK_INTERNAL, 5); lst[4] = mk(CK_MWR, 3);
               cnt = 5;
            end
            K_RMW_XD: begin
               lst[1] = mk(CK_FETCH, 4);    lst[2] = mk(CK_OPND, 3);
               lst[3] = mk(CK_INTERNAL, 5); lst[4] = mk(CK_MRD, 4);
               lst[5] = mk(CK_MWR, 3);
               cnt = 6;
            end
            K_LD_ABS: begin
               lst[1] = mk(CK_OPND_LO, 3); lst[2] = mk(CK_OPND_HI, 3);
               lst[3] = mk(CK_MRD, 3);
               cnt = 4;
            end
            K_LD_IMM16, K_JUMP: begin
               lst[1] = mk(CK_OPND_LO, 3); lst[2] = mk(CK_OPND_HI, 3);
               cnt = 3;
            end
            K_LD_PAIR_ABS: begin
               lst[1] = mk(CK_OPND_LO, 3); lst[2] = mk(CK_OPND_HI, 3);
               lst[3] = mk(CK_MRD_LO, 3);  lst[4] = mk(CK_MRD_HI, 3);
               cnt = 5;
            end
            K_ST_PAIR_ABS: begin
               lst[1] = mk(CK_OPND_LO, 3); lst[2] = mk(CK_OPND_HI, 3);
               lst[3] = mk(CK_MWR_LO, 3);  lst[4] = mk(CK_MWR_HI, 3);
               cnt = 5;
            end
            K_SP_FROM_X, K_DEC_X: begin
               lst[1] = mk(CK_FETCH, 6); cnt = 2;
            end
            K_PUSH, K_RESTART: begin
               lst[0] = mk(CK_FETCH, 5);
               lst[1] = mk(CK_STK_WR_HI, 3); lst[2] = mk(CK_STK_WR_LO, 3);
               cnt = 3;
            end
            K_POP, K_RET: begin
               lst[1] = mk(CK_STK_RD_LO, 3); lst[2] = mk(CK_STK_RD_HI, 3);
               cnt = 3;
            end
            K_XCHG_TOS: begin
               lst[1] = mk(CK_STK_RD_LO, 3); lst[2] = mk(CK_STK_RD_HI, 4);
               lst[3] = mk(CK_STK_WR_HI, 3); lst[4] = mk(CK_STK_WR_LO, 5);
               cnt = 5;
            end
            K_BLK_MOVE: begin
               lst[1] = mk(CK_FETCH, 4); lst[2] = mk(CK_MRD, 3);
               lst[3] = mk(CK_MWR, 5);
               cnt = 4;
               if (rep) begin lst[4] = mk(CK_INTERNAL, 5); cnt = 5; end
            end
            K_RMW_IND: begin
               lst[1] = mk(CK_MRD, 4); lst[2] = mk(CK_MWR, 3); cnt = 3;
            end
            K_TEST_IND: begin
               lst[1] = mk(CK_FETCH, 4); lst[2] = mk(CK_MRD, 4); cnt = 3;
            end
            K_JREL_CC: begin
               lst[1] = mk(CK_OPND, 3); cnt = 2;
               if (cond) begin lst[2] = mk(CK_INTERNAL, 5); cnt = 3; end
            end
            K_DEC_BR: begin
               lst[0] = mk(CK_FETCH, 5);
               lst[1] = mk(CK_OPND, 3); cnt = 2;
               if (cond) begin lst[2] = mk(CK_INTERNAL, 5); cnt = 3; end
            end
            K_CALL: begin
               lst[1] = mk(CK_OPND_LO, 3);   lst[2] = mk(CK_OPND_HI, 4);
               lst[3] = mk(CK_STK_WR_HI, 3); lst[4] = mk(CK_STK_WR_LO, 3);
               cnt = 5;
            end
            K_CALL_CC: begin
               lst[1] = mk(CK_OPND_LO, 3);
               if (cond) begin
                  lst[2] = mk(CK_OPND_HI, 4);
                  lst[3] = mk(CK_STK_WR_HI, 3); lst[4] = mk(CK_STK_WR_LO, 3);
                  cnt = 5;
               end else begin
                  lst[2] = mk(CK_OPND_HI, 3);
                  cnt = 3;
               end
            end
            K_RET_CC: begin
               lst[0] = mk(CK_FETCH, 5);
               if (cond) begin
                  lst[1] = mk(CK_STK_RD_LO, 3); lst[2] = mk(CK_STK_RD_HI, 3);
                  cnt = 3;
               end
            end
            K_IN_IMM: begin
               lst[1] = mk(CK_OPND, 3); lst[2] = mk(CK_IO_RD, 4); cnt = 3;
            end
            K_OUT_IMM: begin
               lst[1] = mk(CK_OPND, 3); lst[2] = mk(CK_IO_WR, 4); cnt = 3;
            end
            K_BLK_IN: begin
               lst[1] = mk(CK_FETCH, 5); lst[2] = mk(CK_IO_RD, 4);
               lst[3] = mk(CK_MWR, 3);
               cnt = 4;
               if (rep) begin lst[4] = mk(CK_INTERNAL, 5); cnt = 5; end
            end
            K_BLK_OUT: begin
               lst[1] = mk(CK_FETCH, 5); lst[2] = mk(CK_MRD, 3);
               lst[3] = mk(CK_IO_WR, 4);
               cnt = 4;
               if (rep) begin lst[4] = mk(CK_INTERNAL, 5); cnt = 5; end
            end
            default: ;
         endcase
      end
      cur = lst[0];
      for (int i = 0; i < MAX_CYC; i++) begin
         if (idx == IDX_W'(i)) cur = lst[i];
      end
      last = (int'(idx) == cnt - 1);
   end

endmodule

// File: rtl/mcyc_tcnt.sv
module mcyc_tcnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] len,
   output logic [W-1:0] t,
   output logic         at_end
);

   assign at_end = (t == len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t <= '0;
      end else if (clr) begin
         t <= '0;
      end else if (adv) begin
         if (at_end) t <= '0;
         else        t <= t + 1'b1;
      end
   end

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int CLS_W = 5,
   parameter int TBASE = 1,
   parameter int IDX_W = $clog2(MAX_CYC),
   parameter int T_W   = LEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              t_en,
   input  logic              start,
   input  logic [CLS_W-1:0]  iclass,
   input  logic              cond_met,
   input  logic              repeat_on,
   output logic [KIND_W-1:0] cyc_type,
   output logic              cyc_start,
   output logic [T_W-1:0]    t_idx,
   output logic              done,
   output logic              busy
);

   localparam int TOP_T = MAX_LEN - 1 + TBASE;

   initial begin
      assert (CLS_W >= 5) else $error("mcyc_seq: CLS_W must be at least 5");
      assert (TBASE == 0 || TBASE == 1) else $error("mcyc_seq: TBASE must be 0 or 1");
      assert ((1 << IDX_W) >= MAX_CYC) else $error("mcyc_seq: IDX_W too small");
      assert ((1 << T_W) > TOP_T) else $error("mcyc_seq: T_W too small");
      assert (T_W >= LEN_W) else $error("mcyc_seq: T_W below LEN_W");
   end

   logic              busy_q;
   logic [CLS_W-1:0]  cls_q;
   logic              cond_q;
   logic              rep_q;
   logic [IDX_W-1:0]  idx_q;
   cyc_t              cur;
   logic              last_c;
   logic [LEN_W-1:0]  t_q;
   logic              t_end;
   logic              accept;
   logic              adv;

   mcyc_table #(.CLS_W(CLS_W), .IDX_W(IDX_W)) u_table (
      .cls  (cls_q),
      .cond (cond_q),
      .rep  (rep_q),
      .idx  (idx_q),
      .cur  (cur),
      .last (last_c)
   );

   assign adv    = t_en && busy_q;
   assign done   = busy_q && t_end && last_c;
   assign accept = t_en && start && (!busy_q || done);

   mcyc_tcnt #(.W(LEN_W)) u_tcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .adv    (adv),
      .len    (cur.len),
      .t      (t_q),
      .at_end (t_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cls_q  <= '0;
         cond_q <= 1'b0;
         rep_q  <= 1'b0;
         idx_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cls_q  <= iclass;
         cond_q <= cond_met;
         rep_q  <= repeat_on;
         idx_q  <= '0;
      end else if (adv && t_end) begin
         if (last_c) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q  <= idx_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign cyc_type  = busy_q ? cur.kind : CK_IDLE;
   assign cyc_start = busy_q && (t_q == '0);

   generate
      if (TBASE == 0) begin : g_tidx_zero
         assign t_idx = T_W'(t_q);
      end else begin : g_tidx_one
         assign t_idx = T_W'(t_q) + T_W'(1);
      end
   endgenerate

endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk
   import mcyc_pkg::*;
#(
   parameter int TBASE = 1,
   parameter int T_W   = LEN_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              t_en,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              cyc_start,
   input logic [KIND_W-1:0] cyc_type,
   input logic [T_W-1:0]    t_idx
);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!t_en && busy) |=> (busy && $stable(cyc_type) && $stable(t_idx) && $stable(done)));

   p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(t_en && start)) |=> !busy);

   p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (t_en && start && (!busy || done)) |=>
         (busy && cyc_type == KIND_W'(1) && cyc_start && t_idx == T_W'(TBASE)));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (t_en && busy && !done) |=>
         (busy && (cyc_start || (t_idx == $past(t_idx) + 1'b1))));

   p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (t_en && done && !start) |=> (!busy && cyc_type == '0));

   p_kind_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cyc_type != '0 && cyc_type <= KIND_W'(17)));

endmodule

bind mcyc_seq mcyc_seq_chk #(.TBASE(TBASE), .T_W(T_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .t_en      (t_en),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .cyc_start (cyc_start),
   .cyc_type  (cyc_type),
   .t_idx     (t_idx)
);

// File: tb/mcyc_seq_tb_top.sv
`timescale 1ns/1ps
module mcyc_seq_tb_top;

   localparam int T_FE = 1,  T_OP = 2,  T_OL = 3,  T_OH = 4;
   localparam int T_MR = 5,  T_ML = 6,  T_MH = 7,  T_MW = 8;
   localparam int T_WL = 9,  T_WH = 10, T_SL = 11, T_SH = 12;
   localparam int T_PH = 13, T_PL = 14, T_IR = 15, T_IW = 16, T_IN = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       t_en = 1'b0;
   logic       start = 1'b0;
   logic [4:0] cls_i = '0;
   logic       cond_i = 1'b0;
   logic       rep_i = 1'b0;
   logic [4:0] cyc_type;
   logic       cyc_start;
   logic [2:0] t_idx;
   logic       done;
   logic       busy;

   always #4 clk = ~clk;

   mcyc_seq dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .t_en      (t_en),
      .start     (start),
      .iclass    (cls_i),
      .cond_met  (cond_i),
      .repeat_on (rep_i),
      .cyc_type  (cyc_type),
      .cyc_start (cyc_start),
      .t_idx     (t_idx),
      .done      (done),
      .busy      (busy)
   );

   int n_chk = 0;
   int n_bad = 0;
   int ety [64];
   int eti [64];
   bit est [64];
   bit edn [64];
   int etot;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic addc(int ty, int len);
      for (int j = 0; j < len; j++) begin
         ety[etot] = ty;
         eti[etot] = j + 1;
         est[etot] = (j == 0);
         edn[etot] = 1'b0;
         etot++;
      end
   endtask

   function automatic string req_of(int c);
      case (c)
         8, 26:            return "R8";
         9, 21:            return "R8 R11";
         2, 3, 15:         return "R9";
         13, 14:           return "R10";
         10, 11, 28:       return "R11";
         16, 17:           return "R12";
         18, 19, 20:       return "R13";
         12, 22, 23, 24, 25: return "R14";
         default:          return "R7";
      endcase
   endfunction

   task automatic build(int c, bit cd, bit rp);
      etot = 0;
      case (c)
         0:  begin addc(T_FE,4); addc(T_MR,3); end
         1:  begin addc(T_FE,4); addc(T_MW,3); end
         2:  begin addc(T_FE,4); addc(T_FE,4); addc(T_OP,3); addc(T_IN,5); addc(T_MR,3); end
         3:  begin addc(T_FE,4); addc(T_FE,4); addc(T_OP,3); addc(T_IN,5); addc(T_MW,3); end
         4:  begin addc(T_FE,4); addc(T_OL,3); addc(T_OH,3); addc(T_MR,3); end
         5, 27: begin addc(T_FE,4); addc(T_OL,3); addc(T_OH,3); end
         6:  begin addc(T_FE,4); addc(T_OL,3); addc(T_OH,3); addc(T_ML,3); addc(T_MH,3); end
         7:  begin addc(T_FE,4); addc(T_OL,3); addc(T_OH,3); addc(T_WL,3); addc(T_WH,3); end
         8, 26: begin addc(T_FE,4); addc(T_FE,6); end
         9, 21: begin addc(T_FE,5); addc(T_PH,3); addc(T_PL,3); end
         10, 28: begin addc(T_FE,4); addc(T_SL,3); addc(T_SH,3); end
         11: begin addc(T_FE,4); addc(T_SL,3); addc(T_SH,4); addc(T_PH,3); addc(T_PL,5); end
         12: begin addc(T_FE,4); addc(T_FE,4); addc(T_MR,3); addc(T_MW,5); if (rp) addc(T_IN,5); end
         13: begin addc(T_FE,4); addc(T_MR,4); addc(T_MW,3); end
         14: begin addc(T_FE,4); addc(T_FE,4); addc(T_MR,4); end
         15: begin addc(T_FE,4); addc(T_FE,4); addc(T_OP,3); addc(T_IN,5); addc(T_MR,4); addc(T_MW,3); end
         16: begin addc(T_FE,4); addc(T_OP,3); if (cd) addc(T_IN,5); end
         17: begin addc(T_FE,5); addc(T_OP,3); if (cd) addc(T_IN,5); end
         18: begin addc(T_FE,4); addc(T_OL,3); addc(T_OH,4); addc(T_PH,3); addc(T_PL,3); end
         19: begin
            addc(T_FE,4); addc(T_OL,3);
            if (cd) begin addc(T_OH,4); addc(T_PH,3); addc(T_PL,3); end
            else    addc(T_OH,3);
         end
         20: begin addc(T_FE,5); if (cd) begin addc(T_SL,3); addc(T_SH,3); end end
         22: begin addc(T_FE,4); addc(T_OP,3); addc(T_IR,4); end
         23: begin addc(T_FE,4); addc(T_OP,3); addc(T_IW,4); end
         24: begin addc(T_FE,4); addc(T_FE,5); addc(T_IR,4); addc(T_MW,3); if (rp) addc(T_IN,5); end
         25: begin addc(T_FE,4); addc(T_FE,5); addc(T_MR,3); addc(T_IW,4); if (rp) addc(T_IN,5); end
         default: addc(T_FE,4);
      endcase
      edn[etot-1] = 1'b1;
   endtask

   task automatic run_one(int c, bit cd, bit rp, int gap);
      int    s;
      bit    bad;
      string why;
      int    av;
      int    ev;
      string rq;
      rq  = req_of(c);
      build(c, cd, rp);
      @(negedge clk);
      cls_i = c[4:0]; cond_i = cd; rep_i = rp; start = 1'b1; t_en = 1'b1;
      @(negedge clk);
      start = 1'b0; cond_i = ~cd; rep_i = ~rp;
      s = 0; bad = 1'b0; why = ""; av = 0; ev = 0;
      while (busy && s < 40) begin
         for (int g = 0; g <= gap; g++) begin
            t_en = (g == gap);
            if (!bad) begin
               if (s >= etot) begin
                  bad = 1'b1; why = "extra T-state step"; av = s; ev = etot;
               end else if (int'(cyc_type) != ety[s]) begin
                  bad = 1'b1; why = $sformatf("cyc_type at step %0d (R6 R3)", s);
                  av = int'(cyc_type); ev = ety[s];
               end else if (int'(t_idx) != eti[s]) begin
                  bad = 1'b1; why = $sformatf("t_idx at step %0d (R4 R3)", s);
                  av = int'(t_idx); ev = eti[s];
               end else if (cyc_start != est[s]) begin
                  bad = 1'b1; why = $sformatf("cyc_start at step %0d (R4)", s);
                  av = int'(cyc_start); ev = int'(est[s]);
               end else if (done != edn[s]) begin
                  bad = 1'b1; why = $sformatf("done at step %0d (R5)", s);
                  av = int'(done); ev = int'(edn[s]);
               end
            end
            @(negedge clk);
         end
         s++;
      end
      t_en = 1'b0;
      chk(!bad, rq, $sformatf("class %0d cond %0d rep %0d gap %0d: %s", c, cd, rp, gap, why), av, ev);
      chk(s == etot, rq, $sformatf("class %0d cond %0d rep %0d total T-states", c, cd, rp), s, etot);
      chk(!busy && cyc_type == 5'd0, "R5", $sformatf("idle after class %0d", c),
          int'(busy) * 100 + int'(cyc_type), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int n;
      // R1: reset state, with start and enable driven during reset
      start = 1'b1; t_en = 1'b1; cls_i = 5'd11;
      repeat (4) @(negedge clk);
      chk(!busy && cyc_type == 5'd0 && !done && !cyc_start, "R1", "outputs during reset",
          int'(busy) + int'(done) + int'(cyc_start) + int'(cyc_type), 0);
      start = 1'b0; t_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && cyc_type == 5'd0, "R1", "idle after reset release", int'(busy), 0);

      // R3: enable without start keeps the block idle
      t_en = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && cyc_type == 5'd0, "R3", "idle with enable and no start", int'(busy), 0);
      t_en = 1'b0;

      // R7..R14 with R2..R6: every class, both flags, with and without enable gaps
      for (int gp = 0; gp <= 2; gp += 2) begin
         for (int c = 0; c < 32; c++) begin
            for (int cd = 0; cd < 2; cd++) begin
               for (int rp = 0; rp < 2; rp++) begin
                  run_one(c, cd[0], rp[0], gp);
               end
            end
         end
      end

      // R2: chained launch in the done T-state of a short instruction
      @(negedge clk);
      cls_i = 5'd0; start = 1'b1; t_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      chk(done == 1'b1, "R2", "done in final T-state before chain", int'(done), 1);
      cls_i = 5'd27; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && cyc_type == 5'd1 && cyc_start && t_idx == 3'd1, "R2",
          "chained instruction opens with fetch T1", int'(cyc_type) * 10 + int'(t_idx), 11);
      n = 0;
      while (busy && n < 40) begin
         n++;
         @(negedge clk);
      end
      t_en = 1'b0;
      chk(n == 10, "R2", "chained jump T-state count", n, 10);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule